// File: doc/BRIEF.md
# Trace Capture Packetizer

The block takes trace words from fabric logic, each made of a data field and a trace ID and marked by a valid strobe on a separate trace clock. It moves them into the system clock domain and turns them into fixed-width packets for a debug trace bus. Besides trace packets, it emits trigger packets when bit 0 of the trigger input rises. It emits overflow packets when its packet queue has had to drop trace words.

Every packet carries a 2-bit type code, an ID field, a data field and the timestamp taken from `tstamp_i` in the cycle the packet is queued. Packets wait in a fixed-depth queue and leave on a valid/ready output. When that queue is full, arriving trace words are discarded and counted. As soon as a slot frees up, a single overflow packet reports how many words were lost.

Top module: `trace_pktzr`

## Requirements
- R1: A trace packet is laid out MSB to LSB as {type[1:0], id[ID_W-1:0], data[DATA_W-1:0], timestamp[TS_W-1:0]}, with type 2'b00. It carries the ID and data of one captured word and the `tstamp_i` value of the cycle it was queued.
- R2: A trace word is captured only on a rising edge of `trc_clk_i` where `trc_valid_i` is high. Captured words leave as trace packets in capture order, with none duplicated or invented.
- R3: A rising edge on `trig_i[0]` produces exactly one trigger packet: type 2'b01, id 0, data 0. Holding the bit high produces no further trigger packets.
- R4: The bits `trig_i[TRIG_W-1:1]` have no effect. Toggling them alone queues no packet.
- R5: The packet queue holds FIFO_DEPTH (default 64) packets. With `pkt_ready_i` low, that many trace packets are retained without loss and later delivered in order.
- R6: A trace word that reaches the formatter while the queue is full is dropped, and no packet is written into a full queue. The overflow packet that follows has type 2'b10 and id 0. Its data field is the number of words dropped, saturating at all ones.
- R7: Only one overflow packet is queued per overflow episode. It is queued in the first cycle the queue has a free slot, ahead of any pending trigger or trace word.
- R8: When a trigger event and a trace word are both ready in the same cycle and no overflow is pending, the trigger packet is queued first. A trigger raised while the queue has room is stamped with the timestamp of the cycle its rising edge is seen.
- R9: A trigger event that arrives while the queue is full is held and queued later. It is not lost.
- R10: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o` stays high and `pkt_o` holds its value.
- R11: While `rst_ni` is low and right after reset, `pkt_valid_o` is low.
- R12: Packets leave with strictly increasing timestamps, because at most one packet is queued per system clock cycle and `tstamp_i` counts up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| trc_clk_i | input | 1 | Trace input clock |
| trc_valid_i | input | 1 | Trace word valid strobe |
| trc_id_i | input | ID_W | Trace ID of the word |
| trc_data_i | input | DATA_W | Trace data of the word |
| trig_i | input | TRIG_W | Trigger inputs; only bit 0 is used |
| tstamp_i | input | TS_W | Free-running timestamp count in the system domain |
| pkt_valid_o | output | 1 | Output packet valid |
| pkt_ready_i | input | 1 | Trace bus ready |
| pkt_o | output | 2+ID_W+DATA_W+TS_W | Output packet |

## Verification
The checks assume that trace words never arrive faster than the formatter can drain the crossing queue. In practice that means the trace clock is no faster than the system clock, so a valid strobe never meets a full crossing queue. They also assume `tstamp_i` counts up by one each system cycle. The bench keeps within these limits with a 7 ns trace clock against the 5 ns system clock and a timestamp counter it advances on every edge. Random traffic uses random gaps and random back-pressure. Directed phases fill the queue exactly, force drops, park a trigger behind a full queue, and line a trigger up with a back-to-back stream of trace words.

// File: rtl/trace_pktzr_pkg.sv
package trace_pktzr_pkg;

  typedef enum logic [1:0] {
    HDR_TRACE = 2'b00,
    HDR_TRIG  = 2'b01,
    HDR_OVF   = 2'b10
  } pkt_hdr_e;

  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/trace_pktzr_cdc.sv
module trace_pktzr_cdc #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic         rst_ni,
  input  logic         wclk_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic         wfull_o,
  input  logic         rclk_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rdata_o,
  output logic         rempty_o
);
  import trace_pktzr_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] ram [DEPTH];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  wgray_s1, wgray_s2, rgray_s1, rgray_s2;
  logic [AW:0]  wbin_nxt, rbin_nxt;
  logic         do_wr, do_rd;

  assign do_wr    = wr_en_i && !wfull_o;
  assign do_rd    = rd_en_i && !rempty_o;
  assign wbin_nxt = wbin + (AW+1)'(1);
  assign rbin_nxt = rbin + (AW+1)'(1);

  // write domain
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_wr) begin
      wbin  <= wbin_nxt;
      wgray <= (AW+1)'(bin2gray(16'(wbin_nxt)));
    end
  end

  always_ff @(posedge wclk_i) begin
    if (do_wr) ram[wbin[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgray_s1 <= '0;
      rgray_s2 <= '0;
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
    end
  end

  assign wfull_o = (wgray == {~rgray_s2[AW:AW-1], rgray_s2[AW-2:0]});

  // read domain
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_rd) begin
      rbin  <= rbin_nxt;
      rgray <= (AW+1)'(bin2gray(16'(rbin_nxt)));
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wgray_s1 <= '0;
      wgray_s2 <= '0;
    end else begin
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
    end
  end

  assign rempty_o = (rgray == wgray_s2);
  assign rdata_o  = ram[rbin[AW-1:0]];

endmodule

// File: rtl/trace_pktzr_fifo.sv
module trace_pktzr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

endmodule

// File: rtl/trace_pktzr_fmt.sv
module trace_pktzr_fmt
  import trace_pktzr_pkg::*;
#(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32,
  localparam int PKT_W = 2 + ID_W + DATA_W + TS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_avail_i,
  input  logic [ID_W-1:0]   word_id_i,
  input  logic [DATA_W-1:0] word_data_i,
  output logic              word_pop_o,
  input  logic              trig_i,
  input  logic [TS_W-1:0]   tstamp_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [PKT_W-1:0]  pkt_o,
  output pkt_hdr_e          push_hdr_o,
  output logic              ovf_pend_o,
  output logic              trig_evt_o
);

  logic              trig_q, trig_pend, ovf_pend;
  logic              trig_evt, drop;
  logic [DATA_W-1:0] drop_cnt;
  logic [ID_W-1:0]   f_id;
  logic [DATA_W-1:0] f_data;
  pkt_hdr_e          hdr;

  assign trig_evt = (trig_i && !trig_q) || trig_pend;

  // priority: overflow, then trigger, then trace
  always_comb begin
    push_o     = 1'b0;
    word_pop_o = 1'b0;
    drop       = 1'b0;
    hdr        = HDR_TRACE;
    f_id       = word_id_i;
    f_data     = word_data_i;
    if (!fifo_full_i) begin
      if (ovf_pend) begin
        push_o = 1'b1;
        hdr    = HDR_OVF;
        f_id   = '0;
        f_data = drop_cnt;
      end else if (trig_evt) begin
        push_o = 1'b1;
        hdr    = HDR_TRIG;
        f_id   = '0;
        f_data = '0;
      end else if (word_avail_i) begin
        push_o     = 1'b1;
        word_pop_o = 1'b1;
      end
    end else if (word_avail_i) begin
      word_pop_o = 1'b1;
      drop       = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q    <= 1'b0;
      trig_pend <= 1'b0;
      ovf_pend  <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      trig_q    <= trig_i;
      trig_pend <= trig_evt && !(push_o && hdr == HDR_TRIG);
      if (drop) ovf_pend <= 1'b1;
      else if (push_o && hdr == HDR_OVF) ovf_pend <= 1'b0;
      if (push_o && hdr == HDR_OVF) drop_cnt <= '0;
      else if (drop && drop_cnt != '1) drop_cnt <= drop_cnt + DATA_W'(1);
    end
  end

  assign pkt_o      = {hdr, f_id, f_data, tstamp_i};
  assign push_hdr_o = hdr;
  assign ovf_pend_o = ovf_pend;
  assign trig_evt_o = trig_evt;

endmodule

// File: rtl/trace_pktzr.sv
module trace_pktzr
  import trace_pktzr_pkg::*;
#(
  parameter int ID_W       = 7,
  parameter int DATA_W     = 32,
  parameter int TS_W       = 32,
  parameter int TRIG_W     = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int CDC_AW     = 3,
  localparam int PKT_W     = 2 + ID_W + DATA_W + TS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trc_clk_i,
  input  logic              trc_valid_i,
  input  logic [ID_W-1:0]   trc_id_i,
  input  logic [DATA_W-1:0] trc_data_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [TS_W-1:0]   tstamp_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [PKT_W-1:0]  pkt_o
);

  localparam int WORD_W = ID_W + DATA_W;

  logic              cdc_full, cdc_empty, word_pop;
  logic [WORD_W-1:0] cdc_rdata;
  logic              fifo_full, fifo_empty, fifo_push;
  logic [PKT_W-1:0]  fmt_pkt;
  pkt_hdr_e          push_hdr;
  logic              ovf_pend, trig_evt;

  generate
    if (TRIG_W > 1) begin : g_spare_trig
      logic unused_trig;
      assign unused_trig = ^trig_i[TRIG_W-1:1];
    end
  endgenerate

  trace_pktzr_cdc #(.W(WORD_W), .AW(CDC_AW)) cdc_i (
    .rst_ni   (rst_ni),
    .wclk_i   (trc_clk_i),
    .wr_en_i  (trc_valid_i),
    .wdata_i  ({trc_id_i, trc_data_i}),
    .wfull_o  (cdc_full),
    .rclk_i   (clk_i),
    .rd_en_i  (word_pop),
    .rdata_o  (cdc_rdata),
    .rempty_o (cdc_empty)
  );

  trace_pktzr_fmt #(.ID_W(ID_W), .DATA_W(DATA_W), .TS_W(TS_W)) fmt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_avail_i (!cdc_empty),
    .word_id_i    (cdc_rdata[WORD_W-1 -: ID_W]),
    .word_data_i  (cdc_rdata[DATA_W-1:0]),
    .word_pop_o   (word_pop),
    .trig_i       (trig_i[0]),
    .tstamp_i     (tstamp_i),
    .fifo_full_i  (fifo_full),
    .push_o       (fifo_push),
    .pkt_o        (fmt_pkt),
    .push_hdr_o   (push_hdr),
    .ovf_pend_o   (ovf_pend),
    .trig_evt_o   (trig_evt)
  );

  trace_pktzr_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .din_i   (fmt_pkt),
    .full_o  (fifo_full),
    .pop_i   (pkt_ready_i),
    .dout_o  (pkt_o),
    .empty_o (fifo_empty)
  );

  assign pkt_valid_o = !fifo_empty;

endmodule

// File: rtl/trace_pktzr_chk.sv
module trace_pktzr_chk #(
  parameter int PKT_W = 73
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trc_clk_i,
  input logic             trc_valid_i,
  input logic             cdc_full,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic [PKT_W-1:0] pkt_o,
  input logic             fifo_full,
  input logic             fifo_push,
  input logic [1:0]       push_hdr,
  input logic             ovf_pend,
  input logic             trig_evt
);

  // R2
  cdc_room_chk: assert property (@(posedge trc_clk_i) disable iff (!rst_ni)
    trc_valid_i |-> !cdc_full);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !fifo_push);

  // R7
  ovf_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pend && !fifo_full) |-> (fifo_push && push_hdr == 2'b10));

  // R8
  trig_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_evt && !ovf_pend && !fifo_full) |-> (fifo_push && push_hdr == 2'b01));

  // R9
  trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_evt && fifo_full) |=> trig_evt);

  // R10
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_o)));

endmodule

bind trace_pktzr trace_pktzr_chk #(.PKT_W(PKT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trc_clk_i   (trc_clk_i),
  .trc_valid_i (trc_valid_i),
  .cdc_full    (cdc_full),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_o       (pkt_o),
  .fifo_full   (fifo_full),
  .fifo_push   (fifo_push),
  .push_hdr    (push_hdr),
  .ovf_pend    (ovf_pend),
  .trig_evt    (trig_evt)
);

// File: tb/trace_pktzr_tb_top.sv
`timescale 1ns/1ps
module trace_pktzr_tb_top;
  localparam int ID_W = 7, DATA_W = 32, TS_W = 32, TRIG_W = 4, DEPTH = 64;
  localparam int PKT_W = 2 + ID_W + DATA_W + TS_W;
  localparam int EW = 2 + ID_W + DATA_W;

  logic clk_i = 0, trc_clk_i = 0, rst_ni = 0;
  logic trc_valid_i = 0;
  logic [ID_W-1:0] trc_id_i = '0;
  logic [DATA_W-1:0] trc_data_i = '0;
  logic [TRIG_W-1:0] trig_i = '0;
  logic [TS_W-1:0] ts_cnt = '0;
  logic pkt_valid_o, pkt_ready_i;
  logic [PKT_W-1:0] pkt_o;

  always #2.5 clk_i = ~clk_i;
  always #3.5 trc_clk_i = ~trc_clk_i;
  always @(posedge clk_i) ts_cnt <= ts_cnt + 1;

  trace_pktzr dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trc_clk_i(trc_clk_i),
    .trc_valid_i(trc_valid_i), .trc_id_i(trc_id_i), .trc_data_i(trc_data_i),
    .trig_i(trig_i), .tstamp_i(ts_cnt),
    .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i), .pkt_o(pkt_o)
  );

  int checks = 0, fails = 0, rx_cnt = 0, trig_seen = 0;
  logic [EW-1:0] exp_q[$];
  bit rand_rdy = 0, rdy_force = 0, loose_trig = 0, ts_seen = 0;
  logic [TS_W-1:0] last_ts = '0, trig_ts = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] exp_trace(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d);
    return {2'b00, id, d};
  endfunction
  function automatic logic [EW-1:0] exp_trig();
    return {2'b01, {ID_W{1'b0}}, {DATA_W{1'b0}}};
  endfunction
  function automatic logic [EW-1:0] exp_ovf(input logic [DATA_W-1:0] n);
    return {2'b10, {ID_W{1'b0}}, n};
  endfunction
  function automatic string tag_of(input logic [1:0] h);
    return (h == 2'b01) ? "R3 trigger" : (h == 2'b10) ? "R6 overflow" : "R1 trace";
  endfunction

  always @(posedge clk_i) begin
    #1;
    pkt_ready_i = rand_rdy ? (($urandom % 4) != 0) : rdy_force;
  end

  // output monitor, sampled between edges
  always @(negedge clk_i) begin
    logic [EW-1:0] got, e;
    logic [TS_W-1:0] ts;
    if (rst_ni && pkt_valid_o && pkt_ready_i) begin
      got = pkt_o[PKT_W-1 -: EW];
      ts  = pkt_o[TS_W-1:0];
      rx_cnt++;
      if (ts_seen) chk(ts > last_ts, "R12 ts order", 64'(ts), 64'(last_ts + 1));
      chk(ts < ts_cnt, "R1 ts bound", 64'(ts), 64'(ts_cnt));
      ts_seen = 1; last_ts = ts;
      if (loose_trig && got[EW-1 -: 2] == 2'b01) begin
        trig_seen++; trig_ts = ts;
      end else if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected packet", 64'(got), 0);
      end else begin
        e = exp_q.pop_front();
        chk(got == e, tag_of(e[EW-1 -: 2]), 64'(got), 64'(e));
      end
    end
  end

  task automatic send_word(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d, input bit keep);
    @(negedge trc_clk_i);
    trc_valid_i = 1; trc_id_i = id; trc_data_i = d;
    if (keep) exp_q.push_back(exp_trace(id, d));
  endtask

  task automatic idle_trc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge trc_clk_i);
      trc_valid_i = 0;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(posedge clk_i);
    wait_clk(10);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rx0;
    void'($urandom(32'd20240611));
    pkt_ready_i = 0;
    wait_clk(5);
    // R11 reset state
    chk(pkt_valid_o == 0, "R11 valid in reset", 64'(pkt_valid_o), 0);
    rst_ni = 1;
    wait_clk(5);
    chk(pkt_valid_o == 0, "R11 valid after reset", 64'(pkt_valid_o), 0);

    // R1/R2: random traffic, random gaps and back-pressure
    rand_rdy = 1;
    for (int i = 0; i < 60; i++) begin
      send_word(ID_W'($urandom), $urandom, 1);
      if ($urandom % 3 == 0) idle_trc(1 + $urandom % 3);
    end
    idle_trc(1);
    wait_drain("R2 random stream drained");
    rand_rdy = 0; rdy_force = 1;

    // R3: held trigger gives one packet
    rx0 = rx_cnt;
    exp_q.push_back(exp_trig());
    wait_clk(1); trig_i[0] = 1;
    wait_clk(20); trig_i[0] = 0;
    wait_drain("R3 trigger drained");
    chk(rx_cnt - rx0 == 1, "R3 single trigger", 64'(rx_cnt - rx0), 1);

    // R4: spare trigger bits ignored
    rx0 = rx_cnt;
    trig_i = 4'b1110;
    wait_clk(5); trig_i = 4'b0100;
    wait_clk(5); trig_i = 4'b1010;
    wait_clk(5); trig_i = 4'b0000;
    wait_clk(20);
    chk(rx_cnt == rx0, "R4 spare bits packets", 64'(rx_cnt - rx0), 0);
    chk(pkt_valid_o == 0, "R4 spare bits valid", 64'(pkt_valid_o), 0);

    // R5/R6/R7/R9: fill, drop, pending trigger, drain
    rdy_force = 0;
    wait_clk(2);
    rx0 = rx_cnt;
    for (int i = 0; i < DEPTH; i++) send_word(ID_W'(i), 32'hA000_0000 + i, 1);
    idle_trc(1);
    wait_clk(20);
    chk(pkt_valid_o == 1, "R5 queue holds", 64'(pkt_valid_o), 1);
    chk(rx_cnt == rx0, "R10 no handshake while not ready", 64'(rx_cnt - rx0), 0);
    for (int i = 0; i < 5; i++) send_word(ID_W'(i), 32'hDEAD_0000 + i, 0);
    idle_trc(1);
    wait_clk(20);
    trig_i[0] = 1; wait_clk(2); trig_i[0] = 0;
    wait_clk(10);
    exp_q.push_back(exp_ovf(32'd5));
    exp_q.push_back(exp_trig());
    rdy_force = 1;
    wait_drain("R7 overflow then R9 trigger drained");
    chk(rx_cnt - rx0 == DEPTH + 2, "R5 packet count", 64'(rx_cnt - rx0), 64'(DEPTH + 2));
    rx0 = rx_cnt;
    for (int i = 0; i < 3; i++) send_word(ID_W'(7 + i), 32'h5555_0000 + i, 1);
    idle_trc(1);
    wait_drain("R7 recovery drained");
    chk(rx_cnt - rx0 == 3, "R7 one overflow per episode", 64'(rx_cnt - rx0), 3);

    // R8: trigger lined up with a back-to-back trace stream
    loose_trig = 1; trig_seen = 0;
    fork
      begin
        for (int i = 0; i < 30; i++) send_word(ID_W'($urandom), $urandom, 1);
        idle_trc(1);
      end
      begin
        logic [TS_W-1:0] want;
        wait_clk(25);
        trig_i[0] = 1; want = ts_cnt;
        wait_clk(3); trig_i[0] = 0;
        wait_clk(60);
        chk(trig_seen == 1, "R3 trigger in stream", 64'(trig_seen), 1);
        chk(trig_ts == want, "R8 trigger not delayed by trace", 64'(trig_ts), 64'(want));
      end
    join
    wait_drain("R8 stream drained");
    loose_trig = 0;
    finish_run();
  end
endmodule